// File: doc/BRIEF.md
# Double-Buffered DAC Code Register

This block is the digital front end of a parallel-input digital-to-analog converter. It holds a data word in two stages. The first stage is a holding register that captures the parallel bus while an active-low write strobe is asserted. The second stage is the code register that feeds the converter core. It copies the holding register while an active-high load strobe is asserted. Several converters can be written one after another and then updated together by one load strobe that all of them share.

Each stage is built as an enable register sampled by the system clock. The strobes are taken as synchronous to that clock. Each stage adds one clock of latency, so with both strobes held active the bus reaches the code output two clocks later. An asynchronous, active-high reset forces both stages to a preset code. That code is zero scale when the centre-select pin is 0. It is midscale (only the top bit set) when the pin is 1. The data width is a parameter: the default is 16 bits, and 14 bits is the narrow variant.

Top module: `dac_dbuf_front`

## Requirements
- R1: The parameter W sets the width of `din` and `code`. The default is 16, and W = 14 must work the same way with its narrower words.
- R2: Asserting `rst` changes `code` to the reset code at once, with no clock edge needed.
- R3: The reset code is all zeros when `mid_sel` = 0. When `mid_sel` = 1 it has bit W-1 set and every other bit clear: 16'h8000 for W = 16 and 14'h2000 for W = 14.
- R4: Reset sets the holding stage as well as the code stage. After `rst` is released, a load with no write in between puts the reset code on `code`.
- R5: While `rst` is high, `wr_n` and `load` have no effect. `code` stays at the reset code.
- R6: At each rising clock edge where `wr_n` = 0, the holding stage captures `din`. Where `wr_n` = 1, it keeps its value, whatever `din` does.
- R7: At each rising clock edge where `load` = 1, `code` takes the value the holding stage had before that edge. At every other edge `code` does not change.
- R8: With `wr_n` held at 0 and `load` held at 1, `code` equals the `din` value from two clocks earlier.
- R9: Instances that share one `load` signal, each written at a different time, all present their new codes after the same clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; both stages sample on its rising edge |
| rst | input | 1 | Asynchronous active-high reset to the preset code |
| mid_sel | input | 1 | Chooses the reset code: 0 gives zero scale, 1 gives midscale |
| wr_n | input | 1 | Active-low write strobe for the holding stage |
| load | input | 1 | Active-high load strobe for the code stage |
| din | input | W | Parallel data bus |
| code | output | W | Code presented to the converter core |

## Verification
The bench builds three instances. Two use the default 16-bit width and one uses the 14-bit width, and all three share one load strobe. Because the two widths run side by side, the bench can check that midscale is placed at the top bit of each width. Because the three instances have separate write strobes and data buses, the bench can write them at different times and then check that they all update on the same load edge. The instances also get different centre-select settings, so a single reset exercises zero scale and midscale at once. The settings are then swapped, so each width is reset to both targets.

// File: rtl/dacfe_pkg.sv
package dacfe_pkg;

    // Number of cascaded register stages (holding, then code)
    localparam int NUM_STAGES = 2;

    // Reset target chosen by the centre-select pin
    typedef enum logic {
        TGT_ZERO = 1'b0,
        TGT_MID  = 1'b1
    } rst_target_e;

    // Stage enables in active-high form, ordered by stage index
    typedef struct packed {
        logic load_en;
        logic write_en;
    } stage_en_t;

endpackage

// File: rtl/dacfe_strobe_dec.sv
module dacfe_strobe_dec
    import dacfe_pkg::*;
(
    input  logic                  wr_n,
    input  logic                  load,
    output logic [NUM_STAGES-1:0] en
);

    stage_en_t s;

    always_comb begin
        s.write_en = ~wr_n;
        s.load_en  = load;
        en         = s;
    end

endmodule

// File: rtl/dacfe_rstval.sv
module dacfe_rstval
    import dacfe_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         mid_sel,
    output logic [W-1:0] rst_val
);

    rst_target_e tgt;

    always_comb begin
        tgt     = rst_target_e'(mid_sel);
        rst_val = '0;
        if (tgt == TGT_MID) begin
            rst_val[W-1] = 1'b1;
        end
    end

endmodule

// File: rtl/dacfe_stage.sv
module dacfe_stage #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] rst_val,
    input  logic         en,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            q <= rst_val;
        end else if (en) begin
            q <= d;
        end
    end

endmodule

// File: rtl/dac_dbuf_front.sv
module dac_dbuf_front
    import dacfe_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         mid_sel,
    input  logic         wr_n,
    input  logic         load,
    input  logic [W-1:0] din,
    output logic [W-1:0] code
);

    logic [NUM_STAGES-1:0] stage_en;
    logic [W-1:0]          rst_val;
    logic [W-1:0]          chain [0:NUM_STAGES];
    logic [W-1:0]          hold_word;

    dacfe_strobe_dec u_dec (
        .wr_n (wr_n),
        .load (load),
        .en   (stage_en)
    );

    dacfe_rstval #(.W(W)) u_rstval (
        .mid_sel (mid_sel),
        .rst_val (rst_val)
    );

    assign chain[0] = din;

    for (genvar g = 0; g < NUM_STAGES; g++) begin : g_stage
        dacfe_stage #(.W(W)) u_stage (
            .clk     (clk),
            .rst     (rst),
            .rst_val (rst_val),
            .en      (stage_en[g]),
            .d       (chain[g]),
            .q       (chain[g+1])
        );
    end

    assign hold_word = chain[1];
    assign code      = chain[NUM_STAGES];

endmodule

// File: rtl/dacfe_chk.sv
module dacfe_chk #(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst,
    input logic         mid_sel,
    input logic         wr_n,
    input logic         load,
    input logic [W-1:0] din,
    input logic [W-1:0] hold_word,
    input logic [W-1:0] code
);

    logic [W-1:0] expect_rst;
    assign expect_rst = mid_sel ? (W'(1) << (W - 1)) : '0;

    AST_CAPTURE_ON_WRITE: assert property (@(posedge clk) disable iff (rst)
        !wr_n |=> hold_word == $past(din)); // R6

    AST_HOLD_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
        wr_n |=> $stable(hold_word)); // R6

    AST_LOAD_COPIES: assert property (@(posedge clk) disable iff (rst)
        load |=> code == $past(hold_word)); // R7

    AST_CODE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        !load |=> $stable(code)); // R7

    AST_RESET_TARGET: assert property (@(negedge clk)
        rst |-> (code == expect_rst) && (hold_word == expect_rst)); // R3

endmodule

bind dac_dbuf_front dacfe_chk #(.W(W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .mid_sel   (mid_sel),
    .wr_n      (wr_n),
    .load      (load),
    .din       (din),
    .hold_word (hold_word),
    .code      (code)
);

// File: tb/test_dac_dbuf_front.sv
module test_dac_dbuf_front;

    logic        clk = 1'b0;
    logic        rst;
    logic        load;
    logic [2:0]  wr_n;
    logic [2:0]  ms;
    logic [15:0] d_a, d_b;
    logic [13:0] d_c;
    logic [15:0] c_a, c_b;
    logic [13:0] c_c;

    int  nchk = 0;
    int  nerr = 0;
    bit  running = 1'b0;
    bit  done = 1'b0;

    // reference model state: index 0,1 are 16-bit, index 2 is 14-bit
    int m_hold [3];
    int m_code [3];
    int wid [3] = '{16, 16, 14};

    always #5 clk = ~clk;

    dac_dbuf_front i_dac_dbuf_front (
        .clk(clk), .rst(rst), .mid_sel(ms[0]), .wr_n(wr_n[0]),
        .load(load), .din(d_a), .code(c_a));

    dac_dbuf_front #(.W(16)) i_dac_b (
        .clk(clk), .rst(rst), .mid_sel(ms[1]), .wr_n(wr_n[1]),
        .load(load), .din(d_b), .code(c_b));

    dac_dbuf_front #(.W(14)) i_dac_c (
        .clk(clk), .rst(rst), .mid_sel(ms[2]), .wr_n(wr_n[2]),
        .load(load), .din(d_c), .code(c_c));

    function automatic int rst_code(int k);
        return ms[k] ? (1 << (wid[k] - 1)) : 0;
    endfunction

    function automatic int din_of(int k);
        case (k)
            0:       return int'(d_a);
            1:       return int'(d_b);
            default: return int'(d_c);
        endcase
    endfunction

    function automatic int code_of(int k);
        case (k)
            0:       return int'(c_a);
            1:       return int'(c_b);
            default: return int'(c_c);
        endcase
    endfunction

    always @(posedge clk or posedge rst) begin
        for (int k = 0; k < 3; k++) begin
            if (rst) begin
                m_hold[k] = rst_code(k);
                m_code[k] = rst_code(k);
            end else begin
                if (load) m_code[k] = m_hold[k];
                if (!wr_n[k]) m_hold[k] = din_of(k);
            end
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // compare every clock against the model
    always @(negedge clk) begin
        if (running) begin
            for (int k = 0; k < 3; k++)
                chk($sformatf("R6 R7 model inst%0d", k), code_of(k), m_code[k]);
        end
    end

    initial begin
        #150000;
        if (!done) begin
            nerr++;
            $display("FAIL R1 watchdog: actual=timeout expected=completion");
            $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
            $finish;
        end
    end

    initial begin
        logic [15:0] vals [8] = '{16'h0001, 16'hFFFF, 16'h8001, 16'h3C3C,
                                  16'hC3C3, 16'h0000, 16'h7FFE, 16'h1234};
        rst = 1'b1; load = 1'b0; wr_n = 3'b111; ms = 3'b110;
        d_a = '0; d_b = '0; d_c = '0;
        repeat (3) @(negedge clk);
        running = 1'b1;
        chk("R3 zero 16", int'(c_a), 'h0000);
        chk("R3 mid 16", int'(c_b), 'h8000);
        chk("R1 R3 mid 14", int'(c_c), 'h2000);
        rst = 1'b0;

        // R6/R7 hold behaviour on instance a
        @(negedge clk); wr_n = 3'b110; d_a = 16'h1234;
        @(negedge clk); chk("R7 no load", int'(c_a), 0);
        wr_n = 3'b111; d_a = 16'hFFFF;
        @(negedge clk); chk("R7 no load 2", int'(c_a), 0);
        load = 1'b1;
        @(negedge clk); load = 1'b0;
        chk("R6 holds after write", int'(c_a), 'h1234);

        // R9 shared load
        @(negedge clk); wr_n = 3'b110; d_a = 16'hAAAA;
        @(negedge clk); wr_n = 3'b101; d_b = 16'hBBBB;
        @(negedge clk); wr_n = 3'b011; d_c = 14'h1555;
        @(negedge clk); wr_n = 3'b111;
        chk("R9 before a", int'(c_a), 'h1234);
        chk("R9 before b", int'(c_b), 'h8000);
        chk("R9 before c", int'(c_c), 'h2000);
        load = 1'b1;
        @(negedge clk); load = 1'b0;
        chk("R9 after a", int'(c_a), 'hAAAA);
        chk("R9 after b", int'(c_b), 'hBBBB);
        chk("R1 R9 after c", int'(c_c), 'h1555);

        // R8 transparent mode
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            if (i >= 2) begin
                chk("R8 pass 16", int'(c_a), int'(vals[i-2]));
                chk("R1 R8 pass 14", int'(c_c), int'(vals[i-2][13:0]));
            end
            if (i < 8) begin
                wr_n = 3'b000; load = 1'b1;
                d_a = vals[i]; d_b = ~vals[i]; d_c = vals[i][13:0];
            end
        end
        wr_n = 3'b111; load = 1'b0;

        // R2 asynchronous reset
        @(negedge clk); #2 rst = 1'b1;
        #1;
        chk("R2 async a", int'(c_a), 0);
        chk("R2 async b", int'(c_b), 'h8000);
        chk("R2 async c", int'(c_c), 'h2000);

        // R5 reset beats strobes
        @(negedge clk); wr_n = 3'b000; load = 1'b1;
        d_a = 16'h5A5A; d_b = 16'hA5A5; d_c = 14'h0F0F;
        repeat (2) @(negedge clk);
        chk("R5 a", int'(c_a), 0);
        chk("R5 b", int'(c_b), 'h8000);
        chk("R5 c", int'(c_c), 'h2000);

        // R4 holding stage also reset
        wr_n = 3'b111; rst = 1'b0;
        repeat (2) @(negedge clk);
        chk("R4 a", int'(c_a), 0);
        chk("R4 b", int'(c_b), 'h8000);
        chk("R4 c", int'(c_c), 'h2000);
        load = 1'b0;

        // R3 swapped targets
        ms = 3'b001; rst = 1'b1;
        repeat (2) @(negedge clk);
        chk("R3 mid 16 swap", int'(c_a), 'h8000);
        chk("R3 zero 16 swap", int'(c_b), 0);
        chk("R1 R3 zero 14 swap", int'(c_c), 0);
        rst = 1'b0;
        repeat (3) @(negedge clk);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

endmodule